// File: doc/BRIEF.md
# Operand-Waiting Issue Queue with Age-Ordered Selection

This block parks operations that have already been renamed until both of their source operands hold values. It then hands one of them per cycle to an execution unit. Each dispatched operation carries an opcode, a destination tag and two sources. A source arrives either as a value already known (for example an immediate or a register that was ready at rename) or as a pending physical-register tag.

A result bus feeds the block. Each cycle it may carry one tag and its value. Every occupied slot compares that tag with its own unresolved sources and latches the value on a match. Among the slots whose sources are both resolved, the one dispatched earliest is issued. Its slot is released at the end of that cycle. Slots still waiting stay where they are. A full flag holds back the dispatcher when every slot is occupied. A flush input empties the whole queue in one cycle.

Top module: `rs_sched`

## Requirements
- R1: After reset no slot is occupied, so `full` and `iss_valid` are both low.
- R2: A dispatch with `disp_valid` high while `full` is low and `flush` is low is stored at the next clock edge. Sources flagged ready keep the supplied value. If both sources are ready, the operation becomes issuable in the cycle after dispatch.
- R3: When `bc_valid` is high, each occupied slot with an unresolved source whose tag equals `bc_tag` latches `bc_val` for that source at the clock edge and marks it resolved.
- R4: A dispatched source that is pending on the tag being broadcast in the same cycle is stored as resolved, holding `bc_val`.
- R5: `iss_valid` is high only when some occupied slot has both sources resolved. A slot with an unresolved source is never issued.
- R6: When several slots can issue, the one dispatched earliest is chosen.
- R7: The issued slot is freed at the clock edge that ends its issue cycle. Slots that are still waiting keep their contents and their age order.
- R8: `full` is high exactly when every slot is occupied. A dispatch offered while `full` is high is discarded.
- R9: `flush` empties every slot at the next clock edge. A dispatch offered in the same cycle is discarded.
- R10: While `iss_valid` is high, `iss_op`, `iss_src1`, `iss_src2` and `iss_dst` carry the opcode, the two resolved values and the destination tag of the chosen slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| flush | input | 1 | Empty all slots at the next edge |
| disp_valid | input | 1 | Dispatch request |
| disp_op | input | OP_W | Opcode of the dispatched operation |
| disp_s1_rdy | input | 1 | Source 1 value already known |
| disp_s1_tag | input | TAG_W | Source 1 pending tag |
| disp_s1_val | input | DATA_W | Source 1 value when ready |
| disp_s2_rdy | input | 1 | Source 2 value already known |
| disp_s2_tag | input | TAG_W | Source 2 pending tag |
| disp_s2_val | input | DATA_W | Source 2 value when ready |
| disp_dst | input | TAG_W | Destination tag |
| full | output | 1 | No free slot; dispatch is ignored |
| bc_valid | input | 1 | Result broadcast present |
| bc_tag | input | TAG_W | Tag of the broadcast result |
| bc_val | input | DATA_W | Value of the broadcast result |
| iss_valid | output | 1 | An operation is issued this cycle |
| iss_op | output | OP_W | Opcode of the issued operation |
| iss_src1 | output | DATA_W | Source 1 value of the issued operation |
| iss_src2 | output | DATA_W | Source 2 value of the issued operation |
| iss_dst | output | TAG_W | Destination tag of the issued operation |

## Verification
Two pairs of events can land in the same cycle. In one, a dispatched source waits on the very tag that is being broadcast. In the other, a flush coincides with a dispatch, and often with an issue as well. Directed phases set up each pair on purpose. Random traffic then keeps reproducing them, because it draws from a small pool of tags and flushes now and then. A reference model in the bench predicts every cycle's issue, ordering entries by a dispatch sequence count. The R4 case counts as correct if the new slot issues the cycle after dispatch with the broadcast value. The R9 case counts as correct if nothing issues after the flush and no dropped dispatch ever shows up.

// File: rtl/rs_pkg.sv
// Shared defaults for the issue queue; modules take these as parameter defaults.
package rs_pkg;
    localparam int RS_ENTRIES_DEF = 8;
    localparam int RS_TAG_W_DEF   = 6;
    localparam int RS_DATA_W_DEF  = 32;
    localparam int RS_OP_W_DEF    = 5;
endpackage

// File: rtl/rs_operand.sv
// One source operand of a slot: loaded at dispatch, then snoops the result bus
// until resolved. Assumes load and active are never asserted for a stale slot.
module rs_operand #(
    parameter int TAG_W  = rs_pkg::RS_TAG_W_DEF,
    parameter int DATA_W = rs_pkg::RS_DATA_W_DEF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic              load_rdy,
    input  logic [TAG_W-1:0]  load_tag,
    input  logic [DATA_W-1:0] load_val,
    input  logic              active,
    input  logic              bc_valid,
    input  logic [TAG_W-1:0]  bc_tag,
    input  logic [DATA_W-1:0] bc_val,
    output logic              rdy,
    output logic [DATA_W-1:0] val
);
    logic [TAG_W-1:0] tag_q;
    logic             hit_now;
    logic             hit_load;

    // Compare the broadcast against the held tag and against the incoming tag.
    always_comb begin
        hit_now  = bc_valid && (bc_tag == tag_q);
        hit_load = bc_valid && (bc_tag == load_tag);
    end

    // Load at dispatch (with same-cycle capture), else capture on a tag match.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdy   <= 1'b0;
            tag_q <= '0;
            val   <= '0;
        end else if (load) begin
            tag_q <= load_tag;
            if (load_rdy) begin
                rdy <= 1'b1;
                val <= load_val;
            end else if (hit_load) begin
                rdy <= 1'b1;
                val <= bc_val;
            end else begin
                rdy <= 1'b0;
            end
        end else if (active && !rdy && hit_now) begin
            rdy <= 1'b1;
            val <= bc_val;
        end
    end

    assert_capture_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (active && !rdy && !load && hit_now) |=> (rdy && val == $past(bc_val)));

    assert_load_capture_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (load && !load_rdy && hit_load) |=> (rdy && val == $past(bc_val)));
endmodule

// File: rtl/rs_entry.sv
// One queue slot: busy flag, opcode, destination and two operands.
// Assumes wr_en only targets a free slot and clr only an occupied one.
module rs_entry #(
    parameter int TAG_W  = rs_pkg::RS_TAG_W_DEF,
    parameter int DATA_W = rs_pkg::RS_DATA_W_DEF,
    parameter int OP_W   = rs_pkg::RS_OP_W_DEF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              flush,
    input  logic              wr_en,
    input  logic [OP_W-1:0]   wr_op,
    input  logic              wr_s1_rdy,
    input  logic [TAG_W-1:0]  wr_s1_tag,
    input  logic [DATA_W-1:0] wr_s1_val,
    input  logic              wr_s2_rdy,
    input  logic [TAG_W-1:0]  wr_s2_tag,
    input  logic [DATA_W-1:0] wr_s2_val,
    input  logic [TAG_W-1:0]  wr_dst,
    input  logic              clr,
    input  logic              bc_valid,
    input  logic [TAG_W-1:0]  bc_tag,
    input  logic [DATA_W-1:0] bc_val,
    output logic              busy,
    output logic              ready,
    output logic [OP_W-1:0]   op,
    output logic [DATA_W-1:0] s1_val,
    output logic [DATA_W-1:0] s2_val,
    output logic [TAG_W-1:0]  dst
);
    logic s1_rdy;
    logic s2_rdy;

    rs_operand #(.TAG_W(TAG_W), .DATA_W(DATA_W)) src1_i (
        .clk(clk), .rst_n(rst_n), .load(wr_en), .load_rdy(wr_s1_rdy),
        .load_tag(wr_s1_tag), .load_val(wr_s1_val), .active(busy),
        .bc_valid(bc_valid), .bc_tag(bc_tag), .bc_val(bc_val),
        .rdy(s1_rdy), .val(s1_val));

    rs_operand #(.TAG_W(TAG_W), .DATA_W(DATA_W)) src2_i (
        .clk(clk), .rst_n(rst_n), .load(wr_en), .load_rdy(wr_s2_rdy),
        .load_tag(wr_s2_tag), .load_val(wr_s2_val), .active(busy),
        .bc_valid(bc_valid), .bc_tag(bc_tag), .bc_val(bc_val),
        .rdy(s2_rdy), .val(s2_val));

    // Occupancy: set by dispatch, cleared by issue or flush.
    always_ff @(posedge clk) begin
        if (!rst_n || flush) busy <= 1'b0;
        else if (wr_en)      busy <= 1'b1;
        else if (clr)        busy <= 1'b0;
    end

    // Opcode and destination are captured at dispatch only.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            op  <= '0;
            dst <= '0;
        end else if (wr_en) begin
            op  <= wr_op;
            dst <= wr_dst;
        end
    end

    // Issuable when occupied and both operands resolved.
    always_comb ready = busy && s1_rdy && s2_rdy;

    assert_free_after_issue_R7: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> !busy);

    assert_issue_only_ready_R5: assert property (@(posedge clk) disable iff (!rst_n)
        clr |-> (busy && s1_rdy && s2_rdy));
endmodule

// File: rtl/rs_age.sv
// Age matrix: older_q[i][j] set means slot i was dispatched before slot j.
// Picks the eligible slot that no other eligible slot is older than.
module rs_age #(
    parameter int ENTRIES = rs_pkg::RS_ENTRIES_DEF
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [ENTRIES-1:0] wr_vec,
    input  logic [ENTRIES-1:0] elig,
    output logic [ENTRIES-1:0] grant
);
    logic [ENTRIES-1:0] older_q [ENTRIES];

    // A new slot becomes younger than every other slot.
    always_ff @(posedge clk) begin
        for (int i = 0; i < ENTRIES; i++) begin
            for (int j = 0; j < ENTRIES; j++) begin
                if (!rst_n)         older_q[i][j] <= 1'b0;
                else if (wr_vec[i]) older_q[i][j] <= 1'b0;
                else if (wr_vec[j]) older_q[i][j] <= 1'b1;
            end
        end
    end

    // Grant an eligible slot with no older eligible slot.
    always_comb begin
        for (int i = 0; i < ENTRIES; i++) begin
            logic blocked;
            blocked = 1'b0;
            for (int j = 0; j < ENTRIES; j++) begin
                if (j != i && elig[j] && older_q[j][i]) blocked = 1'b1;
            end
            grant[i] = elig[i] && !blocked;
        end
    end

    assert_single_grant_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grant));

    assert_grant_when_any_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (elig != '0) |-> (grant != '0));
endmodule

// File: rtl/rs_free_pick.sv
// Chooses the lowest-numbered free slot and reports when none is left.
module rs_free_pick #(
    parameter int ENTRIES = rs_pkg::RS_ENTRIES_DEF
) (
    input  logic [ENTRIES-1:0] busy,
    output logic [ENTRIES-1:0] pick,
    output logic               full
);
    // Priority scan from slot 0 upward.
    always_comb begin
        logic found;
        found = 1'b0;
        pick  = '0;
        for (int i = 0; i < ENTRIES; i++) begin
            if (!busy[i] && !found) begin
                pick[i] = 1'b1;
                found   = 1'b1;
            end
        end
        full = !found;
    end
endmodule

// File: rtl/rs_sched.sv
// Issue queue top: dispatch into a free slot, snoop the result bus in every
// slot, issue the oldest slot with both operands resolved. Assumes the
// execution unit always accepts an issued operation.
module rs_sched #(
    parameter int ENTRIES = rs_pkg::RS_ENTRIES_DEF,
    parameter int TAG_W   = rs_pkg::RS_TAG_W_DEF,
    parameter int DATA_W  = rs_pkg::RS_DATA_W_DEF,
    parameter int OP_W    = rs_pkg::RS_OP_W_DEF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              flush,
    input  logic              disp_valid,
    input  logic [OP_W-1:0]   disp_op,
    input  logic              disp_s1_rdy,
    input  logic [TAG_W-1:0]  disp_s1_tag,
    input  logic [DATA_W-1:0] disp_s1_val,
    input  logic              disp_s2_rdy,
    input  logic [TAG_W-1:0]  disp_s2_tag,
    input  logic [DATA_W-1:0] disp_s2_val,
    input  logic [TAG_W-1:0]  disp_dst,
    output logic              full,
    input  logic              bc_valid,
    input  logic [TAG_W-1:0]  bc_tag,
    input  logic [DATA_W-1:0] bc_val,
    output logic              iss_valid,
    output logic [OP_W-1:0]   iss_op,
    output logic [DATA_W-1:0] iss_src1,
    output logic [DATA_W-1:0] iss_src2,
    output logic [TAG_W-1:0]  iss_dst
);
    logic [ENTRIES-1:0] busy_vec;
    logic [ENTRIES-1:0] elig_vec;
    logic [ENTRIES-1:0] grant_vec;
    logic [ENTRIES-1:0] pick_vec;
    logic [ENTRIES-1:0] wr_vec;
    logic               accept;
    logic [OP_W-1:0]    e_op   [ENTRIES];
    logic [DATA_W-1:0]  e_s1   [ENTRIES];
    logic [DATA_W-1:0]  e_s2   [ENTRIES];
    logic [TAG_W-1:0]   e_dst  [ENTRIES];

    rs_free_pick #(.ENTRIES(ENTRIES)) free_i (
        .busy(busy_vec), .pick(pick_vec), .full(full));

    // Dispatch lands in the picked slot unless full or flushing.
    always_comb begin
        accept = disp_valid && !full && !flush;
        wr_vec = accept ? pick_vec : '0;
    end

    generate
        for (genvar g = 0; g < ENTRIES; g++) begin : g_slot
            rs_entry #(.TAG_W(TAG_W), .DATA_W(DATA_W), .OP_W(OP_W)) slot_i (
                .clk(clk), .rst_n(rst_n), .flush(flush),
                .wr_en(wr_vec[g]), .wr_op(disp_op),
                .wr_s1_rdy(disp_s1_rdy), .wr_s1_tag(disp_s1_tag), .wr_s1_val(disp_s1_val),
                .wr_s2_rdy(disp_s2_rdy), .wr_s2_tag(disp_s2_tag), .wr_s2_val(disp_s2_val),
                .wr_dst(disp_dst), .clr(grant_vec[g]),
                .bc_valid(bc_valid), .bc_tag(bc_tag), .bc_val(bc_val),
                .busy(busy_vec[g]), .ready(elig_vec[g]),
                .op(e_op[g]), .s1_val(e_s1[g]), .s2_val(e_s2[g]), .dst(e_dst[g]));
        end
    endgenerate

    rs_age #(.ENTRIES(ENTRIES)) age_i (
        .clk(clk), .rst_n(rst_n), .wr_vec(wr_vec), .elig(elig_vec), .grant(grant_vec));

    // One-hot OR mux from the granted slot onto the issue port.
    always_comb begin
        iss_valid = |grant_vec;
        iss_op    = '0;
        iss_src1  = '0;
        iss_src2  = '0;
        iss_dst   = '0;
        for (int i = 0; i < ENTRIES; i++) begin
            if (grant_vec[i]) begin
                iss_op   = iss_op   | e_op[i];
                iss_src1 = iss_src1 | e_s1[i];
                iss_src2 = iss_src2 | e_s2[i];
                iss_dst  = iss_dst  | e_dst[i];
            end
        end
    end

    assert_flush_empties_R9: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (busy_vec == '0));

    assert_full_holds_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (full && !iss_valid && !flush) |=> full);

    assert_no_write_when_full_R8: assert property (@(posedge clk) disable iff (!rst_n)
        full |-> (wr_vec == '0));
endmodule

// File: tb/rs_sched_tb.sv
// Bench: directed corner phases, then seeded random traffic, all checked
// against an order-based reference model of the queue.
module rs_sched_tb_top;
    localparam int E  = 4;
    localparam int TW = 4;
    localparam int DW = 16;
    localparam int OW = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic flush = 1'b0;
    logic disp_valid = 1'b0;
    logic [OW-1:0] disp_op = '0;
    logic disp_s1_rdy = 1'b0, disp_s2_rdy = 1'b0;
    logic [TW-1:0] disp_s1_tag = '0, disp_s2_tag = '0, disp_dst = '0;
    logic [DW-1:0] disp_s1_val = '0, disp_s2_val = '0;
    logic full;
    logic bc_valid = 1'b0;
    logic [TW-1:0] bc_tag = '0;
    logic [DW-1:0] bc_val = '0;
    logic iss_valid;
    logic [OW-1:0] iss_op;
    logic [DW-1:0] iss_src1, iss_src2;
    logic [TW-1:0] iss_dst;

    always #2 clk = ~clk;

    rs_sched #(.ENTRIES(E), .TAG_W(TW), .DATA_W(DW), .OP_W(OW)) dut_i (
        .clk(clk), .rst_n(rst_n), .flush(flush), .disp_valid(disp_valid),
        .disp_op(disp_op), .disp_s1_rdy(disp_s1_rdy), .disp_s1_tag(disp_s1_tag),
        .disp_s1_val(disp_s1_val), .disp_s2_rdy(disp_s2_rdy), .disp_s2_tag(disp_s2_tag),
        .disp_s2_val(disp_s2_val), .disp_dst(disp_dst), .full(full),
        .bc_valid(bc_valid), .bc_tag(bc_tag), .bc_val(bc_val),
        .iss_valid(iss_valid), .iss_op(iss_op), .iss_src1(iss_src1),
        .iss_src2(iss_src2), .iss_dst(iss_dst));

    // Reference model: slots ordered by a dispatch sequence number.
    logic          m_busy [E];
    int            m_seq  [E];
    logic [OW-1:0] m_op   [E];
    logic          m_r1   [E], m_r2 [E];
    logic [TW-1:0] m_t1   [E], m_t2 [E], m_dst [E];
    logic [DW-1:0] m_v1   [E], m_v2 [E];
    int seq_ctr = 0;
    int total = 0;
    int bad = 0;
    bit finished = 0;
    string phase = "R1";

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s phase %s: actual %0h expected %0h", req, phase, act, exp);
        end
    endtask

    function automatic int oldest_ready();
        int ei = -1;
        for (int k = 0; k < E; k++)
            if (m_busy[k] && m_r1[k] && m_r2[k] && (ei < 0 || m_seq[k] < m_seq[ei])) ei = k;
        return ei;
    endfunction

    function automatic int count_busy();
        int c = 0;
        for (int k = 0; k < E; k++) if (m_busy[k]) c++;
        return c;
    endfunction

    task automatic check_outputs();
        int ei = oldest_ready();
        chk("R8", 32'(full), 32'(count_busy() == E));
        chk("R5", 32'(iss_valid), 32'(ei >= 0));
        if (ei >= 0 && iss_valid) begin
            chk("R6", 32'(iss_dst), 32'(m_dst[ei]));
            chk("R10", 32'(iss_op), 32'(m_op[ei]));
            chk("R10", 32'(iss_src1), 32'(m_v1[ei]));
            chk("R10", 32'(iss_src2), 32'(m_v2[ei]));
        end
    endtask

    task automatic model_update();
        int ei = oldest_ready();
        int nb = count_busy();
        if (!rst_n || flush) begin
            for (int k = 0; k < E; k++) m_busy[k] = 1'b0;
            return;
        end
        for (int k = 0; k < E; k++) begin
            if (m_busy[k] && bc_valid) begin
                if (!m_r1[k] && m_t1[k] == bc_tag) begin m_r1[k] = 1'b1; m_v1[k] = bc_val; end
                if (!m_r2[k] && m_t2[k] == bc_tag) begin m_r2[k] = 1'b1; m_v2[k] = bc_val; end
            end
        end
        if (disp_valid && nb < E) begin
            int f = -1;
            for (int k = 0; k < E; k++) if (!m_busy[k] && f < 0) f = k;
            m_busy[f] = 1'b1; m_seq[f] = seq_ctr++; m_op[f] = disp_op; m_dst[f] = disp_dst;
            m_t1[f] = disp_s1_tag; m_t2[f] = disp_s2_tag;
            m_r1[f] = disp_s1_rdy || (bc_valid && bc_tag == disp_s1_tag);
            m_v1[f] = disp_s1_rdy ? disp_s1_val : bc_val;
            m_r2[f] = disp_s2_rdy || (bc_valid && bc_tag == disp_s2_tag);
            m_v2[f] = disp_s2_rdy ? disp_s2_val : bc_val;
        end
        if (ei >= 0) m_busy[ei] = 1'b0;
    endtask

    task automatic go_idle();
        disp_valid = 1'b0; bc_valid = 1'b0; flush = 1'b0;
    endtask

    task automatic tick();
        check_outputs();
        @(posedge clk);
        model_update();
        @(negedge clk);
        go_idle();
    endtask

    task automatic disp(logic [OW-1:0] op, logic r1, logic [TW-1:0] t1, logic [DW-1:0] v1,
                        logic r2, logic [TW-1:0] t2, logic [DW-1:0] v2, logic [TW-1:0] d);
        disp_valid = 1'b1; disp_op = op;
        disp_s1_rdy = r1; disp_s1_tag = t1; disp_s1_val = v1;
        disp_s2_rdy = r2; disp_s2_tag = t2; disp_s2_val = v2;
        disp_dst = d;
    endtask

    task automatic bcast(logic [TW-1:0] t, logic [DW-1:0] v);
        bc_valid = 1'b1; bc_tag = t; bc_val = v;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            total++; bad++;
            $display("FAIL watchdog phase %s: actual hung expected done", phase);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4242));
        for (int k = 0; k < E; k++) m_busy[k] = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: empty after reset
        phase = "R1";
        chk("R1", 32'(full), 32'd0);
        chk("R1", 32'(iss_valid), 32'd0);
        tick();
        // R2: both-ready dispatch issues the next cycle
        phase = "R2";
        disp(4'h3, 1, 0, 16'h1111, 1, 0, 16'h2222, 4'h1); tick();
        chk("R2", 32'(iss_valid), 32'd1);
        chk("R2", 32'(iss_src2), 32'h2222);
        tick();
        // R3: wait on tag 5, then broadcast it
        phase = "R3";
        disp(4'h4, 0, 4'h5, 0, 1, 0, 16'h0007, 4'h2); tick();
        tick(); tick();
        bcast(4'h5, 16'hBEEF); tick();
        chk("R3", 32'(iss_src1), 32'hBEEF);
        tick();
        // R4: dispatch and matching broadcast in the same cycle
        phase = "R4";
        disp(4'h5, 1, 0, 16'h0A0A, 0, 4'h7, 0, 4'h3); bcast(4'h7, 16'hCAFE); tick();
        chk("R4", 32'(iss_src2), 32'hCAFE);
        tick();
        // R7: a waiting slot stays while younger ready slots issue past it
        phase = "R7";
        disp(4'h6, 0, 4'h9, 0, 1, 0, 16'h0001, 4'h4); tick();
        disp(4'h7, 1, 0, 16'h0002, 1, 0, 16'h0003, 4'h5); tick();
        disp(4'h8, 1, 0, 16'h0004, 1, 0, 16'h0005, 4'h6); tick();
        tick();
        chk("R7", 32'(iss_valid), 32'd0);
        bcast(4'h9, 16'h0099); tick();
        tick();
        // R8: fill every slot with waiters, offer one more, then release
        phase = "R8";
        for (int n = 0; n < E + 1; n++) begin
            disp(4'h9, 0, 4'hC, 0, 1, 0, 16'(n), 4'(8 + n)); tick();
        end
        chk("R8", 32'(full), 32'd1);
        // R6: all released together, must leave in dispatch order
        phase = "R6";
        bcast(4'hC, 16'h0C0C); tick();
        for (int n = 0; n < E + 1; n++) tick();
        // R9: flush with queued waiters and a same-cycle dispatch
        phase = "R9";
        disp(4'h1, 0, 4'hD, 0, 1, 0, 16'h1, 4'hA); tick();
        disp(4'h2, 1, 0, 16'h2, 1, 0, 16'h3, 4'hB); flush = 1'b1; tick();
        chk("R9", 32'(iss_valid), 32'd0);
        bcast(4'hD, 16'h00DD); tick();
        chk("R9", 32'(iss_valid), 32'd0);
        tick();
        // Random traffic over a small tag pool
        phase = "RND";
        for (int c = 0; c < 4000; c++) begin
            if ($urandom_range(99) < 60)
                disp(4'($urandom), 1'($urandom_range(1)), 4'($urandom_range(7)), 16'($urandom),
                     1'($urandom_range(1)), 4'($urandom_range(7)), 16'($urandom), 4'($urandom));
            if ($urandom_range(99) < 40) bcast(4'($urandom_range(7)), 16'($urandom));
            if ($urandom_range(99) < 1) flush = 1'b1;
            tick();
        end
        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule